// File: doc/BRIEF.md
# Receive Wire-Polarity Detector and Corrector

This block decides whether the two wires of a twisted-pair receive channel have been swapped, and undoes the swap in the sliced receive bit stream. It uses two sources of evidence.

The first source is the end of each frame. An upstream receiver strobes the moment the idle tail starts and reports whether that tail settled positive or negative. A positive tail means the wires are correct, and a negative tail means they are reversed. The polarity decision moves only when a run of consecutive frames agree.

The second source is the link pulses. When the link has failed and no frames arrive, a run of link pulses that are seen inverted flips the current decision, so that the link can come back up.

The corrected bit leaves through one register stage. A status output reports the detected wire state whether or not correction is applied. A disable input bypasses the correction but leaves detection running.

Top module: `rx_pol_fix`

## Requirements
- R1: After reset, `pol_ok_o` is 1 (wires assumed correct) and `data_o` is 0. All vote and pulse counters start at zero.
- R2: On a cycle with `eof_stb_i` high, `eof_neg_i` = 0 means the idle tail stayed positive (a vote for correct wires). `eof_neg_i` = 1 means the tail ended negative (a vote for reversed wires).
- R3: The polarity decision changes only on the FRAME_VOTES-th (default 4) consecutive frame strobe whose tail sign agrees. The new status is visible on `pol_ok_o` in the cycle after that strobe.
- R4: A frame whose tail sign differs from the running candidate restarts the agreement count at one, with that frame's sign as the new candidate. The decision is left unchanged.
- R5: `pol_ok_o` is 1 when the decision is "correct" and 0 when it is "reversed".
- R6: `data_o` equals `rx_data_i` XOR the reversed decision, registered once. It changes in the cycle after the input changes.
- R7: While `pol_dis_i` is 1, `data_o` is `rx_data_i` delayed one cycle and is never inverted. Detection continues, and `pol_ok_o` still follows R3, R4 and R8.
- R8: While `link_fail_i` is 1, the LP_FLIPS-th (default 5) consecutive `inv_lp_i` strobe toggles the decision, and the pulse count then restarts from zero. Any cycle with `link_fail_i` low clears the pulse count.
- R9: A frame strobe clears the pulse count. A frame strobe in the same cycle as the completing inverted pulse wins: that pulse does not toggle the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Sliced receive data bit |
| eof_stb_i | input | 1 | Start-of-idle strobe at end of frame |
| eof_neg_i | input | 1 | Idle tail sign, 1 = negative |
| inv_lp_i | input | 1 | Strobe: link pulse received inverted |
| link_fail_i | input | 1 | Link currently failed |
| pol_dis_i | input | 1 | Bypass correction |
| data_o | output | 1 | Corrected data, one register stage |
| pol_ok_o | output | 1 | 1 = wires correct, 0 = reversed |

## Verification
The frame vote and the link-pulse recovery can both try to act on the decision in the same cycle. A frame strobe can arrive together with the inverted pulse that would complete the recovery count.

The bench brings the pulse count to one short of the limit. It then raises the last pulse and a disagreeing frame strobe on the same clock edge. It judges the result from `pol_ok_o`: the status must not toggle. A further full run of pulses must then be needed before it does, which shows that the count was cleared rather than wrapped.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;
  typedef enum logic {
    POL_OK  = 1'b0,
    POL_REV = 1'b1
  } pol_e;
endpackage

// File: rtl/rx_pol_vote.sv
module rx_pol_vote #(
  parameter int unsigned VOTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  rx_pol_pkg::pol_e sign_i,
  output logic            set_o,
  output rx_pol_pkg::pol_e val_o
);
  import rx_pol_pkg::*;
  localparam int unsigned CW = $clog2(VOTES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  pol_e          cand_q, cand_d;

  always_comb begin
    cnt_d  = cnt_q;
    cand_d = cand_q;
    if (stb_i) begin
      if (cnt_q == '0 || sign_i != cand_q) begin
        cand_d = sign_i;
        cnt_d  = CW'(1);
      end else if (cnt_q != CW'(VOTES)) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  assign set_o = stb_i && (cnt_d == CW'(VOTES));
  assign val_o = cand_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cand_q <= POL_OK;
    end else begin
      cnt_q  <= cnt_d;
      cand_q <= cand_d;
    end
  end

  // R3
  vote_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(VOTES));
  // R4
  vote_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && cnt_q != '0 && sign_i != cand_q) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/rx_pol_lp.sv
module rx_pol_lp #(
  parameter int unsigned FLIPS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inv_lp_i,
  input  logic link_fail_i,
  input  logic clr_i,
  output logic flip_o
);
  localparam int unsigned LW = (FLIPS > 1) ? $clog2(FLIPS) : 1;

  logic [LW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == LW'(FLIPS - 1));
  assign flip_o = link_fail_i && inv_lp_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !link_fail_i) cnt_q <= '0;
    else if (inv_lp_i)             cnt_q <= last ? '0 : cnt_q + LW'(1);
  end

  // R8
  lp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < LW'(FLIPS));
  // R8
  lp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_fail_i |=> (cnt_q == '0));
  // R9
  lp_frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rx_pol_fix.sv
module rx_pol_fix #(
  parameter int unsigned FRAME_VOTES = 4,
  parameter int unsigned LP_FLIPS    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  input  logic eof_stb_i,
  input  logic eof_neg_i,
  input  logic inv_lp_i,
  input  logic link_fail_i,
  input  logic pol_dis_i,
  output logic data_o,
  output logic pol_ok_o
);
  import rx_pol_pkg::*;

  pol_e pol_q;
  pol_e vote_val;
  logic vote_set, lp_flip, data_q;

  rx_pol_vote #(.VOTES(FRAME_VOTES)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (eof_stb_i),
    .sign_i (pol_e'(eof_neg_i)),
    .set_o  (vote_set),
    .val_o  (vote_val)
  );

  rx_pol_lp #(.FLIPS(LP_FLIPS)) u_lp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inv_lp_i    (inv_lp_i),
    .link_fail_i (link_fail_i),
    .clr_i       (eof_stb_i),
    .flip_o      (lp_flip)
  );

  // frame vote has priority; lp block already masks flip on a frame strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= POL_OK;
    else if (vote_set) pol_q <= vote_val;
    else if (lp_flip)  pol_q <= (pol_q == POL_OK) ? POL_REV : POL_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= 1'b0;
    else         data_q <= rx_data_i ^ ((pol_q == POL_REV) && !pol_dis_i);
  end

  assign data_o   = data_q;
  assign pol_ok_o = (pol_q == POL_OK);

  // R3
  pol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pol_ok_o) |-> $past(vote_set || lp_flip));
  // R7
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_dis_i |=> (data_o == $past(rx_data_i)));
  // R9
  frame_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_stb_i && !vote_set) |=> $stable(pol_ok_o));
endmodule

// File: tb/tb_rx_pol_fix.sv
module tb_rx_pol_fix;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_data = 1'b0, eof_stb = 1'b0, eof_neg = 1'b0;
  logic inv_lp = 1'b0, link_fail = 1'b0, pol_dis = 1'b0;
  logic data_o, pol_ok_o;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pol_fix dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data), .eof_stb_i(eof_stb),
    .eof_neg_i(eof_neg), .inv_lp_i(inv_lp), .link_fail_i(link_fail),
    .pol_dis_i(pol_dis), .data_o(data_o), .pol_ok_o(pol_ok_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic frame(input logic neg);
    eof_stb = 1'b1; eof_neg = neg;
    @(negedge clk);
    eof_stb = 1'b0; eof_neg = 1'b0;
  endtask

  task automatic pulse();
    inv_lp = 1'b1;
    @(negedge clk);
    inv_lp = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pol_ok", pol_ok_o, 1'b1);
    check("R1 data", data_o, 1'b0);
  endtask

  task automatic t_pass();
    rx_data = 1'b1;
    @(negedge clk);
    check("R6 data straight", data_o, 1'b1);
    rx_data = 1'b0;
    @(negedge clk);
    check("R6 data straight 0", data_o, 1'b0);
  endtask

  task automatic t_vote();
    for (int i = 0; i < 3; i++) frame(1'b1);
    check("R3 three votes hold", pol_ok_o, 1'b1);
    frame(1'b1);
    check("R3 R5 R2 fourth vote reverses", pol_ok_o, 1'b0);
    rx_data = 1'b1;
    @(negedge clk);
    check("R6 data inverted", data_o, 1'b0);
    rx_data = 1'b0;
    @(negedge clk);
    check("R6 data inverted 0", data_o, 1'b1);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 3; i++) frame(1'b0);
    frame(1'b1);
    for (int i = 0; i < 3; i++) frame(1'b0);
    check("R4 restart blocks change", pol_ok_o, 1'b0);
    frame(1'b0);
    check("R4 R2 four positive tails", pol_ok_o, 1'b1);
  endtask

  task automatic t_disable();
    for (int i = 0; i < 4; i++) frame(1'b1);
    pol_dis = 1'b1;
    rx_data = 1'b1;
    @(negedge clk);
    check("R7 bypass data", data_o, 1'b1);
    check("R7 status kept", pol_ok_o, 1'b0);
    pol_dis = 1'b0;
    @(negedge clk);
    check("R7 correction back", data_o, 1'b0);
    rx_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_lp();
    link_fail = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) pulse();
    check("R8 four pulses hold", pol_ok_o, 1'b0);
    pulse();
    check("R8 fifth pulse flips", pol_ok_o, 1'b1);
    for (int i = 0; i < 3; i++) pulse();
    link_fail = 1'b0;
    @(negedge clk);
    link_fail = 1'b1;
    for (int i = 0; i < 4; i++) pulse();
    check("R8 link up clears count", pol_ok_o, 1'b1);
    pulse();
    check("R8 flip after restart", pol_ok_o, 1'b0);
  endtask

  task automatic t_collide();
    for (int i = 0; i < 4; i++) pulse();
    inv_lp = 1'b1; eof_stb = 1'b1; eof_neg = 1'b0;
    @(negedge clk);
    inv_lp = 1'b0; eof_stb = 1'b0;
    check("R9 frame beats fifth pulse", pol_ok_o, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) pulse();
    check("R9 count cleared by frame", pol_ok_o, 1'b0);
    pulse();
    check("R9 full run flips", pol_ok_o, 1'b1);
    link_fail = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_vote();
    t_restart();
    t_disable();
    t_lp();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule